// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor Table

This block guesses whether a conditional branch will be taken. It keeps a direct-mapped array of two-bit saturating counters. A few low-order bits of the program counter select one entry. The fetch stage presents a PC on the lookup side and at once receives a taken / not-taken guess. When the branch resolves, the back end sends the branch PC and its real direction on the training side. The selected counter then steps one state toward that direction.

Two counter states on each side give hysteresis. Because of this, a loop branch that is taken many times and then falls through once costs a single wrong guess per exit, not two. A build parameter picks how the index is cut from the PC:

- **Word-aligned mode** assumes fixed four-byte instructions. It skips PC bits [1:0], which are always zero.
- **Byte mode** is for variable-length code that may start on any byte. It uses the lowest PC bits directly.

Top module: `dir_pred_table`

## Requirements
- R1: After reset every counter holds state 1 (weakly not-taken), so every lookup PC reads as not-taken (`pred_taken` = 0) until training occurs.
- R2: A counter in state 2 or 3 gives `pred_taken` = 1. A counter in state 0 or 1 gives `pred_taken` = 0. The counter's upper bit is the guess.
- R3: A valid taken update raises the selected counter by one and saturates at 3. After any number of taken updates, a single not-taken update still leaves the entry predicting taken.
- R4: A valid not-taken update lowers the selected counter by one and saturates at 0. After any number of not-taken updates, a single taken update still leaves the entry predicting not-taken.
- R5: With `BYTE_ALIGNED` = 0, the index is PC bits [IDX_W+1:2]. PCs that differ only in bits [1:0], or only in bits above IDX_W+1, share an entry. PCs that differ in bits [IDX_W+1:2] do not share an entry.
- R6: With `BYTE_ALIGNED` = 1, the index is PC bits [IDX_W-1:0]. PCs that differ in bits [1:0] use distinct entries. PCs that differ only in bits at or above IDX_W share an entry.
- R7: While `upd_valid` is 0, no counter changes, whatever `upd_pc` and `upd_taken` hold.
- R8: The lookup is combinational from the stored counters. When a lookup and an update select the same entry in one cycle, the lookup returns the value from before the update. The trained value is visible from the next cycle on.
- R9: For a loop branch with a repeating pattern of seven taken outcomes followed by one not-taken outcome, once the entry is warm each loop exit costs exactly one misprediction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counters update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Guess for `pred_pc`: 1 = taken |
| upd_valid | input | 1 | Training strobe for the current cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch: 1 = taken |

## Verification
A lookup result is due in the same cycle as its PC, with no register in the path. A training request changes what lookups see only after the next rising clock edge.

The bench therefore works as follows:
- Inputs are driven on the falling edge.
- Expected guesses are computed from the counter model as it stood before that cycle's training.
- The guess is sampled one nanosecond later, well before the rising edge.
- The model applies the training only after the sample is taken.

This keeps same-cycle reads and trains separate. Two instances, one per indexing mode, receive identical stimulus, so aliasing differences show up side by side.

// File: rtl/bp_dir_pkg.sv
package bp_dir_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WEAK_NT;

    // one training step toward the resolved direction, clamped at both ends
    function automatic ctr_e ctr_train(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_RESET;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_dir(input ctr_e cur);
        return (cur == CTR_WEAK_T) || (cur == CTR_STRONG_T);
    endfunction

endpackage

// File: rtl/pc_index_hash.sv
module pc_index_hash #(
    parameter int PC_W         = 32,
    parameter int IDX_W        = 6,
    parameter bit BYTE_ALIGNED = 1'b0
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);

    localparam int SHIFT = BYTE_ALIGNED ? 0 : 2;
    localparam int TOP   = IDX_W + SHIFT;

    generate
        if (SHIFT > 0) begin : g_word
            // fixed-length code: bits [1:0] never vary, skip them
            assign idx = pc[TOP-1:SHIFT];
            logic unused_low;
            assign unused_low = ^pc[SHIFT-1:0];
        end else begin : g_byte
            assign idx = pc[IDX_W-1:0];
        end

        if (TOP < PC_W) begin : g_high
            logic unused_high;
            assign unused_high = ^pc[PC_W-1:TOP];
        end
    endgenerate

endmodule

// File: rtl/sat_ctr_step.sv
module sat_ctr_step
    import bp_dir_pkg::*;
(
    input  ctr_e cur,
    input  logic taken,
    output ctr_e nxt,
    output logic dir
);

    always_comb begin
        nxt = ctr_train(cur, taken);
        dir = ctr_dir(cur);
    end

endmodule

// File: rtl/ctr_bank.sv
module ctr_bank
    import bp_dir_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_taken,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic                    rd_dir,
    output logic [ENTRIES-1:0][1:0] ctr_all
);

    typedef struct packed {
        ctr_e [ENTRIES-1:0] ctr;
    } bank_t;

    bank_t bank_d, bank_q;
    ctr_e  wr_cur, wr_nxt, rd_cur;
    logic  unused_wr_dir;

    assign wr_cur = bank_q.ctr[wr_idx];
    assign rd_cur = bank_q.ctr[rd_idx];

    sat_ctr_step u_wr_step (
        .cur   (wr_cur),
        .taken (wr_taken),
        .nxt   (wr_nxt),
        .dir   (unused_wr_dir)
    );

    // the read sees bank_q, so a same-cycle write is not forwarded
    assign rd_dir = ctr_dir(rd_cur);

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            bank_d.ctr[wr_idx] = wr_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= {ENTRIES{CTR_RESET}};
        end else begin
            bank_q <= bank_d;
        end
    end

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_view
            assign ctr_all[e] = bank_q.ctr[e];
        end
    endgenerate

endmodule

// File: rtl/dir_pred_table.sv
module dir_pred_table #(
    parameter int PC_W         = 32,
    parameter int ENTRIES      = 64,
    parameter bit BYTE_ALIGNED = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0]        pred_idx;
    logic [IDX_W-1:0]        upd_idx;
    logic [ENTRIES-1:0][1:0] ctr_all;

    pc_index_hash #(
        .PC_W(PC_W), .IDX_W(IDX_W), .BYTE_ALIGNED(BYTE_ALIGNED)
    ) u_hash_rd (
        .pc  (pred_pc),
        .idx (pred_idx)
    );

    pc_index_hash #(
        .PC_W(PC_W), .IDX_W(IDX_W), .BYTE_ALIGNED(BYTE_ALIGNED)
    ) u_hash_wr (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    ctr_bank #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .rd_idx   (pred_idx),
        .rd_dir   (pred_taken),
        .ctr_all  (ctr_all)
    );

endmodule

// File: rtl/dir_pred_checker.sv
module dir_pred_checker #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    upd_valid,
    input logic                    upd_taken,
    input logic [IDX_W-1:0]        upd_idx,
    input logic [ENTRIES-1:0][1:0] ctr_all
);

    localparam logic [ENTRIES-1:0][1:0] ALL_WEAK_NT = {ENTRIES{2'b01}};

    assert_reset_weak_nt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctr_all == ALL_WEAK_NT));

    assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && ctr_all[upd_idx] != 2'd3)
        |=> (ctr_all[$past(upd_idx)] == $past(ctr_all[upd_idx]) + 2'd1));

    assert_sat_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && ctr_all[upd_idx] == 2'd3)
        |=> (ctr_all[$past(upd_idx)] == 2'd3));

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && ctr_all[upd_idx] != 2'd0)
        |=> (ctr_all[$past(upd_idx)] == $past(ctr_all[upd_idx]) - 2'd1));

    assert_sat_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && ctr_all[upd_idx] == 2'd0)
        |=> (ctr_all[$past(upd_idx)] == 2'd0));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ctr_all));

endmodule

bind dir_pred_table dir_pred_checker #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .upd_idx   (upd_idx),
    .ctr_all   (ctr_all)
);

// File: tb/sim_dir_pred_table.sv
module sim_dir_pred_table;

    localparam int PC_W    = 32;
    localparam int ENTRIES = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_valid = 1'b0;
    logic            upd_taken = 1'b0;
    logic            pt_word, pt_byte;

    always #2 clk = ~clk;   // 250 MHz

    dir_pred_table #(.PC_W(PC_W), .ENTRIES(ENTRIES), .BYTE_ALIGNED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_word),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

    dir_pred_table #(.PC_W(PC_W), .ENTRIES(ENTRIES), .BYTE_ALIGNED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_byte),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

    typedef struct {
        logic  exp_word;
        logic  exp_byte;
        string req;
    } item_t;

    item_t q[$];
    event  go;
    int    checks = 0;
    int    fails = 0;
    int    m_word[ENTRIES];
    int    m_byte[ENTRIES];
    logic  last_word;

    function automatic int ix_word(input logic [PC_W-1:0] pc);
        return int'((pc >> 2) % ENTRIES);
    endfunction

    function automatic int ix_byte(input logic [PC_W-1:0] pc);
        return int'(pc % ENTRIES);
    endfunction

    function automatic int trained(input int c, input logic t);
        if (t) return (c < 3) ? c + 1 : 3;
        return (c > 0) ? c - 1 : 0;
    endfunction

    // driver: one cycle of stimulus, expected guesses from pre-update model
    task automatic step(input logic [PC_W-1:0] ppc, input logic v,
                        input logic [PC_W-1:0] upc, input logic t, input string req);
        item_t it;
        @(negedge clk);
        pred_pc = ppc; upd_valid = v; upd_pc = upc; upd_taken = t;
        it.exp_word = (m_word[ix_word(ppc)] >= 2);
        it.exp_byte = (m_byte[ix_byte(ppc)] >= 2);
        it.req = req;
        q.push_back(it);
        -> go;
        #1;
        last_word = pt_word;
        if (v) begin
            m_word[ix_word(upc)] = trained(m_word[ix_word(upc)], t);
            m_byte[ix_byte(upc)] = trained(m_byte[ix_byte(upc)], t);
        end
    endtask

    // monitor: compare the combinational guess inside the cycle
    initial begin
        forever begin
            item_t it;
            @go;
            #1;
            it = q.pop_front();
            checks++;
            if (pt_word !== it.exp_word) begin
                fails++;
                $display("FAIL %s word-mode pred_pc=%h actual=%b expected=%b",
                         it.req, pred_pc, pt_word, it.exp_word);
            end
            checks++;
            if (pt_byte !== it.exp_byte) begin
                fails++;
                $display("FAIL %s byte-mode pred_pc=%h actual=%b expected=%b",
                         it.req, pred_pc, pt_byte, it.exp_byte);
            end
        end
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            m_word[i] = 1;
            m_byte[i] = 1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: untrained entries read not-taken
        step(32'h0000_0000, 1'b0, '0, 1'b0, "R1");
        step(32'h0000_07FC, 1'b0, '0, 1'b0, "R1");
        step(32'h0000_0123, 1'b0, '0, 1'b0, "R1");

        // R2 / R3: walk up to and past the top state
        for (int i = 0; i < 5; i++) step(32'h108, 1'b1, 32'h108, 1'b1, "R2");
        step(32'h108, 1'b1, 32'h108, 1'b0, "R3");
        step(32'h108, 1'b0, '0, 1'b0, "R3");   // state 2: still taken

        // R4: walk down to and past the floor
        for (int i = 0; i < 5; i++) step(32'h108, 1'b1, 32'h108, 1'b0, "R4");
        step(32'h108, 1'b1, 32'h108, 1'b1, "R4");
        step(32'h108, 1'b0, '0, 1'b0, "R4");   // state 1: still not-taken

        // R7: taken requests without the strobe must not flip the entry
        for (int i = 0; i < 3; i++) step(32'h108, 1'b0, 32'h108, 1'b1, "R7");

        // R8: same-entry read and train in one cycle returns the old value
        step(32'h108, 1'b1, 32'h108, 1'b1, "R8");
        step(32'h108, 1'b0, '0, 1'b0, "R8");

        // R5 / R6: aliasing per indexing mode
        step(32'h10C, 1'b1, 32'h10C, 1'b1, "R5");
        step(32'h10C, 1'b1, 32'h10C, 1'b1, "R5");
        step(32'h10D, 1'b0, '0, 1'b0, "R5");   // word: shared; byte: own entry
        step(32'h10F, 1'b0, '0, 1'b0, "R6");
        step(32'h110, 1'b0, '0, 1'b0, "R5");   // next word entry untouched
        step(32'h30C, 1'b0, '0, 1'b0, "R5");   // high bits alias in word mode
        step(32'h14C, 1'b0, '0, 1'b0, "R6");   // high bits alias in byte mode

        // R9: seven taken then one exit, three loops
        for (int lp = 0; lp < 3; lp++) begin
            int miss = 0;
            for (int it = 0; it < 8; it++) begin
                logic outc = (it != 7);
                step(32'h3F0, 1'b1, 32'h3F0, outc, "R9");
                if (last_word != outc) miss++;
            end
            if (lp > 0) begin
                checks++;
                if (miss != 1) begin
                    fails++;
                    $display("FAIL R9 loop=%0d mispredicts actual=%0d expected=1", lp, miss);
                end
            end
        end

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule